// File: doc/BRIEF.md
# Rotate Unit with Carry-Out

This block rotates a 32-bit operand to the right and produces the carry flag that the rotate leaves behind. Two operations are offered. The first is a rotate right by a variable amount taken from an 8-bit field. The second is a one-place rotate right through the carry, where the incoming carry enters the top bit and bit 0 leaves as the new carry.

A flag-setting enable decides whether the carry output follows the rotate or simply returns the incoming carry. The amount field is reduced modulo the word width. The one exception is an amount of zero: it passes both the operand and the carry through untouched. A nonzero multiple of 32 leaves the value unchanged but still moves bit 31 into the carry.

The unit fits between operand fetch and flag write-back in an execution pipeline. Its outputs are registered once, behind an input strobe.

Top module: `rot_unit`

## Requirements
- R1: With extend mode off (`op_ext`=0) and a reduced amount s from 1 to 31, `result` is the operand rotated right by s places: bit i of `result` equals operand bit (i+s) mod 32.
- R2: With extend mode off and `amount` equal to 0, `result` equals the operand and `carry_out` equals `carry_in`, whatever `set_flags` is.
- R3: With extend mode off and `amount` a nonzero multiple of 32 (32, 64, 96, ... 224), `result` equals the operand. When `set_flags` is 1, `carry_out` equals operand bit 31.
- R4: An amount above 32 acts as that amount reduced by 32 as many times as needed. So 33 acts as 1, 64 as 32, 65 as 1 and 255 as 31.
- R5: With extend mode off, `set_flags`=1 and a nonzero amount n, `carry_out` equals operand bit ((n-1) mod 32).
- R6: With `op_ext`=1, `result` equals {`carry_in`, operand[31:1]}. The `amount` input then has no effect.
- R7: With `op_ext`=1 and `set_flags`=1, `carry_out` equals operand bit 0.
- R8: With `set_flags`=0, `carry_out` equals `carry_in` for every operation and amount.
- R9: `result` and `carry_out` are registered on the clock edge at which `in_valid` is 1. `out_valid` is 1 in exactly the cycle after each cycle with `in_valid` high.
- R10: While `in_valid` is 0, `result` and `carry_out` keep their last values.
- R11: Synchronous active-high `rst` clears `out_valid`, `result` and `carry_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: capture this cycle's operation |
| operand | input | 32 | Value to rotate |
| amount | input | 8 | Rotate distance, reduced modulo 32 (0 means no rotate) |
| op_ext | input | 1 | 0: rotate by amount, 1: one-place rotate through carry |
| set_flags | input | 1 | 1: carry follows the rotate, 0: carry passes through |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Registered strobe, one cycle after in_valid |
| result | output | 32 | Registered rotated value |
| carry_out | output | 1 | Registered carry flag |

## Verification
Two functions can act in one cycle: the modulo reduction of the amount and the carry selection. For an amount of 32, 64 or 224, the reduced rotate is zero, yet the carry must still come from bit 31 and not from `carry_in`. The bench provokes this with operands whose bit 31 differs from `carry_in`, and with amounts like 65 and 255 whose carry index wraps. Each captured result and carry is compared against a bit-serial reference model that rotates one place at a time.

// File: rtl/rot_unit.sv
module rot_unit #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  operand,
  input  logic [AW-1:0] amount,
  input  logic          op_ext,
  input  logic          set_flags,
  input  logic          carry_in,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic          carry_out
);

  localparam int SW = $clog2(W);

  logic [SW-1:0] sh;
  logic [SW-1:0] cidx;
  logic          zero_amt;
  logic [W-1:0]  ror_val;
  logic [W-1:0]  nxt_res;
  logic          nxt_c;

  assign sh       = amount[SW-1:0];
  assign cidx     = sh - SW'(1);
  assign zero_amt = (amount == '0);
  assign ror_val  = (operand >> sh) | (operand << (W - int'(sh)));

  always_comb begin
    if (op_ext) begin
      nxt_res = {carry_in, operand[W-1:1]};
      nxt_c   = set_flags ? operand[0] : carry_in;
    end else if (zero_amt) begin
      nxt_res = operand;
      nxt_c   = carry_in;
    end else begin
      nxt_res = ror_val;
      nxt_c   = set_flags ? operand[cidx] : carry_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_res;
        carry_out <= nxt_c;
      end
    end
  end

endmodule

// File: rtl/rot_unit_chk.sv
module rot_unit_chk #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [W-1:0]  operand,
  input logic [AW-1:0] amount,
  input logic          op_ext,
  input logic          set_flags,
  input logic          carry_in,
  input logic          out_valid,
  input logic [W-1:0]  result,
  input logic          carry_out
);

  localparam int SW = $clog2(W);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r8_carry_passthru: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !set_flags) |=> (carry_out == $past(carry_in)));

  a_r6_extend_result: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_ext) |=> (result == {$past(carry_in), $past(operand[W-1:1])}));

  a_r7_extend_carry: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_ext && set_flags) |=> (carry_out == $past(operand[0])));

  a_r2_zero_amount: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_ext && amount == '0) |=>
      (result == $past(operand) && carry_out == $past(carry_in)));

  a_r3_full_turn: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_ext && set_flags && amount != '0 && amount[SW-1:0] == '0) |=>
      (result == $past(operand) && carry_out == $past(operand[W-1])));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(carry_out)));

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !carry_out));

endmodule

bind rot_unit rot_unit_chk #(.W(W), .AW(AW)) i_chk (.*);

// File: tb/test_rot_unit.sv
module test_rot_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] operand = '0;
  logic [7:0]  amount = '0;
  logic        op_ext = 1'b0;
  logic        set_flags = 1'b0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        carry_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  rot_unit i_rot_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
    .amount(amount), .op_ext(op_ext), .set_flags(set_flags),
    .carry_in(carry_in), .out_valid(out_valid), .result(result),
    .carry_out(carry_out)
  );

  always #4 clk = ~clk;

  // {op_ext, set_flags, carry_in, amount, operand}
  localparam int NV = 20;
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 8'd1,   32'h8000_0001},
    {1'b0, 1'b1, 1'b0, 8'd4,   32'h1234_5678},
    {1'b0, 1'b1, 1'b1, 8'd31,  32'h4000_0000},
    {1'b0, 1'b1, 1'b0, 8'd16,  32'hDEAD_BEEF},
    {1'b0, 1'b1, 1'b1, 8'd0,   32'h0F0F_0F0F},
    {1'b0, 1'b0, 1'b1, 8'd0,   32'hA5A5_A5A5},
    {1'b0, 1'b1, 1'b0, 8'd32,  32'h8000_0000},
    {1'b0, 1'b1, 1'b1, 8'd32,  32'h7FFF_FFFF},
    {1'b0, 1'b1, 1'b0, 8'd33,  32'h0000_0001},
    {1'b0, 1'b1, 1'b0, 8'd64,  32'hC000_0003},
    {1'b0, 1'b1, 1'b1, 8'd65,  32'h0000_0002},
    {1'b0, 1'b1, 1'b0, 8'd255, 32'h4000_0000},
    {1'b0, 1'b1, 1'b1, 8'd224, 32'h0000_0001},
    {1'b0, 1'b0, 1'b0, 8'd7,   32'hFFFF_FFFF},
    {1'b0, 1'b0, 1'b1, 8'd32,  32'h0000_0000},
    {1'b1, 1'b1, 1'b1, 8'd0,   32'h0000_0003},
    {1'b1, 1'b1, 1'b0, 8'd9,   32'h8000_0000},
    {1'b1, 1'b0, 1'b1, 8'd200, 32'h0000_0001},
    {1'b1, 1'b0, 1'b0, 8'd3,   32'hFFFF_FFFE},
    {1'b0, 1'b1, 1'b0, 8'd100, 32'h0000_0008}
  };

  task automatic model(input logic [31:0] op, input logic [7:0] amt, input logic cin,
                       input logic ext, input logic sf,
                       output logic [31:0] r, output logic c);
    logic [31:0] v;
    logic lastc;
    int n;
    n = amt;
    lastc = cin;
    if (ext) begin
      r = {cin, op[31:1]};
      lastc = op[0];
    end else if (n == 0) begin
      r = op;
    end else begin
      while (n > 32) n = n - 32;
      v = op;
      for (int k = 0; k < n; k++) begin
        lastc = v[0];
        v = {v[0], v[31:1]};
      end
      r = v;
    end
    c = sf ? lastc : cin;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run_op(input string req, input logic ext, input logic sf, input logic cin,
                        input logic [7:0] amt, input logic [31:0] op);
    logic [31:0] er;
    logic ec;
    model(op, amt, cin, ext, sf, er, ec);
    @(negedge clk);
    in_valid = 1'b1; op_ext = ext; set_flags = sf; carry_in = cin;
    amount = amt; operand = op;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " result"}, result, er);
    check({req, " carry"}, {31'd0, carry_out}, {31'd0, ec});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 out_valid", {31'd0, out_valid}, 32'd0);
    check("R11 result", result, 32'd0);
    check("R11 carry", {31'd0, carry_out}, 32'd0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R6 R7 R8: vector walk against bit-serial model
    for (int i = 0; i < NV; i++)
      run_op("R1-vector", VEC[i][42], VEC[i][41], VEC[i][40], VEC[i][39:32], VEC[i][31:0]);

    // R1 R5: hand-computed values
    run_op("R1", 1'b0, 1'b1, 1'b0, 8'd4, 32'h1234_5678);
    check("R1 hand", result, 32'h8123_4567);
    check("R5 hand", {31'd0, carry_out}, 32'd1);
    // R3: full turn keeps value, carry from bit 31
    run_op("R3", 1'b0, 1'b1, 1'b0, 8'd32, 32'h8000_0001);
    check("R3 hand", result, 32'h8000_0001);
    check("R3 carry", {31'd0, carry_out}, 32'd1);
    // R4: 65 acts as 1
    run_op("R4", 1'b0, 1'b1, 1'b1, 8'd65, 32'h0000_0002);
    check("R4 hand", result, 32'h0000_0001);
    check("R4 carry", {31'd0, carry_out}, 32'd0);
    // R2: zero amount keeps carry_in even with flags on
    run_op("R2", 1'b0, 1'b1, 1'b1, 8'd0, 32'h0000_0000);
    check("R2 carry", {31'd0, carry_out}, 32'd1);
    // R6 R7: extend mode
    run_op("R6", 1'b1, 1'b1, 1'b1, 8'd17, 32'h0000_0003);
    check("R6 hand", result, 32'h8000_0001);
    check("R7 hand", {31'd0, carry_out}, 32'd1);
    // R8: flags off
    run_op("R8", 1'b1, 1'b0, 1'b0, 8'd0, 32'h0000_0001);
    check("R8 hand", {31'd0, carry_out}, 32'd0);

    // R9 R10: idle cycles with changing inputs
    run_op("R10", 1'b0, 1'b1, 1'b0, 8'd8, 32'h0000_01FF);
    operand = 32'hFFFF_0000; amount = 8'd3; carry_in = 1'b1; op_ext = 1'b1;
    @(negedge clk);
    check("R9 idle valid", {31'd0, out_valid}, 32'd0);
    check("R10 hold result", result, 32'hFF00_0001);
    check("R10 hold carry", {31'd0, carry_out}, 32'd1);
    @(negedge clk);
    check("R10 hold result 2", result, 32'hFF00_0001);

    // R9: back-to-back strobes
    @(negedge clk);
    in_valid = 1'b1; op_ext = 1'b0; set_flags = 1'b1; carry_in = 1'b0;
    amount = 8'd1; operand = 32'h0000_0002;
    @(negedge clk);
    check("R9 b2b valid1", {31'd0, out_valid}, 32'd1);
    check("R9 b2b result1", result, 32'h0000_0001);
    amount = 8'd2;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 b2b valid2", {31'd0, out_valid}, 32'd1);
    check("R9 b2b result2", result, 32'h8000_0000);
    check("R9 b2b carry2", {31'd0, carry_out}, 32'd1);

    // R11: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R11 again result", result, 32'd0);
    check("R11 again valid", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule